// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces the periodic interrupt of a PC-style real-time clock. A 15-bit count runs freely and advances once per 32.768 kHz tick strobe. A 4-bit rate code and an enable bit select a period of 2^(n-1) ticks. Whenever the count lands on a whole multiple of that period, both periodic status flags are set and the interrupt request goes high.

Interrupts are phase-aligned to the free-running count. They are not timed from the moment the rate was programmed. Changing the rate mid-period moves the next event to the next boundary of the new period in absolute count terms. Turning the generator off does not stop or reset the count.

The flags and the request stay set until the host pulses the status-clear input.

Top module: `periodic_rate_gen`

## Requirements
- R1: After synchronous active-high reset, `irq` is 0, `status_flags` is 2'b00, and the tick count is 0.
- R2: For rate codes 3 to 15 with the enable high, an event occurs on every tick that brings the count to a multiple of 2^(code-1). Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R3: Rate code 1 behaves as code 8 (period 128 ticks) and rate code 2 behaves as code 9 (period 256 ticks).
- R4: With rate code 0 or `per_en` low, no event occurs, and `irq` and `status_flags` stay as they are.
- R5: The count advances on every tick whatever the rate and enable are. After a change of rate or enable, the next event falls on the next multiple of the new period of that count.
- R6: An event sets `status_flags` to 2'b11 and `irq` to 1 one clock after the tick. Bit 1 is the status register's bit 7 and bit 0 is its bit 6.
- R7: `irq` and `status_flags` hold until a `status_clr` pulse, which clears both on the next clock.
- R8: If an event and `status_clr` occur in the same cycle, the event wins and the flags stay set.
- R9: A cycle with `tick_32k` low neither advances the count nor raises an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle strobe at 32.768 kHz |
| rate_code | input | 4 | Rate select field, 0 = off |
| per_en | input | 1 | Periodic interrupt enable |
| status_clr | input | 1 | Pulse that clears flags and request (host read of the status register) |
| status_flags | output | 2 | Periodic status bits {bit7, bit6} |
| irq | output | 1 | Interrupt request, held until cleared |

## Verification
The hardest case to reach is a rate change in the middle of a period. The next event must then land on an absolute boundary of the new period, not one period after the change. That difference is only visible if the bench knows the hidden tick count exactly.

The bench counts every tick it issues from reset onward. It reprograms the rate at a chosen count, for example from period 16 to period 8 at count 10. It also disables the generator for a few ticks and expects the count to keep running. Separately, it drives a clear on the very tick of an event while the flags are already set, to reach the set-over-clear case.

// File: rtl/prd_pkg.sv
package prd_pkg;
  // Map a raw rate code to its effective code (1,2 alias to 8,9).
  function automatic logic [3:0] eff_code(input logic [3:0] code);
    if (code == 4'd1 || code == 4'd2) return code + 4'd7;
    return code;
  endfunction
endpackage

// File: rtl/prd_timebase.sv
module prd_timebase #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_next
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_next = cnt_q + 1'b1;
endmodule

// File: rtl/prd_rate_decode.sv
module prd_rate_decode #(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] rate_code,
  input  logic              per_en,
  output logic              active,
  output logic [CNT_W-1:0]  phase_mask
);
  import prd_pkg::*;
  localparam int SH_W = $clog2(CNT_W);

  logic [3:0]      eff;
  logic [SH_W-1:0] sh;

  always_comb begin
    eff        = eff_code(4'(rate_code));
    sh         = SH_W'(eff - 4'd1);
    active     = per_en && (rate_code != '0);
    phase_mask = (CNT_W'(1) << sh) - CNT_W'(1);
  end
endmodule

// File: rtl/prd_flags.sv
module prd_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic       clr,
  output logic [1:0] flags,
  output logic       irq
);
  logic hit_q;

  always_ff @(posedge clk) begin
    if (rst)       hit_q <= 1'b0;
    else if (fire) hit_q <= 1'b1;
    else if (clr)  hit_q <= 1'b0;
  end

  assign flags = {hit_q, hit_q};
  assign irq   = hit_q;
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_32k,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              per_en,
  input  logic              status_clr,
  output logic [1:0]        status_flags,
  output logic              irq
);
  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] phase_mask;
  logic             active;
  logic             fire_w;

  prd_timebase #(.CNT_W(CNT_W)) tb_u (
    .clk(clk), .rst(rst), .tick(tick_32k), .cnt_next(cnt_next)
  );

  prd_rate_decode #(.CNT_W(CNT_W), .CODE_W(CODE_W)) dec_u (
    .rate_code(rate_code), .per_en(per_en),
    .active(active), .phase_mask(phase_mask)
  );

  assign fire_w = tick_32k && active && ((cnt_next & phase_mask) == '0);

  prd_flags flg_u (
    .clk(clk), .rst(rst), .fire(fire_w), .clr(status_clr),
    .flags(status_flags), .irq(irq)
  );
endmodule

// File: rtl/prd_checker.sv
module prd_checker #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_32k,
  input logic [CODE_W-1:0] rate_code,
  input logic              per_en,
  input logic              status_clr,
  input logic [1:0]        status_flags,
  input logic              irq,
  input logic              fire_w
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!irq && status_flags == 2'b00));
  a_r6_event_sets: assert property (@(posedge clk) disable iff (rst)
    fire_w |=> (irq && status_flags == 2'b11));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !status_clr) |=> irq);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (status_clr && !fire_w) |=> (!irq && status_flags == 2'b00));
  a_r4_off_silent: assert property (@(posedge clk) disable iff (rst)
    (!per_en || rate_code == '0) |-> !fire_w);
  a_r9_no_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_32k |-> !fire_w);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (fire_w && status_clr) |=> irq);
endmodule

bind periodic_rate_gen prd_checker #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst(rst), .tick_32k(tick_32k), .rate_code(rate_code),
  .per_en(per_en), .status_clr(status_clr), .status_flags(status_flags),
  .irq(irq), .fire_w(fire_w)
);

// File: tb/periodic_rate_gen_tb_top.sv
module periodic_rate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_32k = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       per_en = 1'b0;
  logic       status_clr = 1'b0;
  logic [1:0] status_flags;
  logic       irq;

  int n_checks = 0;
  int n_fail = 0;
  bit exp_q[$];
  string tag_q[$];
  int unsigned m_cnt = 0;
  bit m_flag = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  periodic_rate_gen dut_i (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .rate_code(rate_code),
    .per_en(per_en), .status_clr(status_clr),
    .status_flags(status_flags), .irq(irq)
  );

  function automatic int unsigned period_of(input logic [3:0] c);
    logic [3:0] e;
    e = (c == 4'd1 || c == 4'd2) ? c + 4'd7 : c;
    return 32'd1 << (e - 1);
  endfunction

  task automatic check(input bit exp, input string tag);
    n_checks++;
    if ({status_flags, irq} !== {exp, exp, exp}) begin
      n_fail++;
      $display("FAIL %s: flags=%b irq=%b expected flags=%b%b irq=%b",
               tag, status_flags, irq, exp, exp, exp);
    end
  endtask

  // driver: one tick (optionally with clear), expected result queued
  task automatic tick_once(input bit clr, input string tag);
    @(negedge clk);
    tick_32k = 1'b1;
    status_clr = clr;
    m_cnt = (m_cnt + 1) % 32768;
    if (clr) m_flag = 1'b0;
    if (per_en && rate_code != 0 && (m_cnt % period_of(rate_code)) == 0) m_flag = 1'b1;
    exp_q.push_back(m_flag);
    tag_q.push_back(tag);
    @(negedge clk);
    tick_32k = 1'b0;
    status_clr = 1'b0;
  endtask

  task automatic clear_only(input string tag);
    @(negedge clk);
    status_clr = 1'b1;
    m_flag = 1'b0;
    exp_q.push_back(m_flag);
    tag_q.push_back(tag);
    @(negedge clk);
    status_clr = 1'b0;
  endtask

  task automatic idle_chk(input string tag);
    @(negedge clk);
    exp_q.push_back(m_flag);
    tag_q.push_back(tag);
  endtask

  // n ticks; when the model flag rises, verify hold then clear it
  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick_once(1'b0, tag);
      if (m_flag) begin
        idle_chk("R7 hold");
        clear_only("R7 clear");
      end
    end
  endtask

  // monitor: compare one queued item per cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1'b0, "R1 reset state");

    // R1/R2: code 3 -> first event on tick 4 (counter started at 0)
    rate_code = 4'd3;
    per_en = 1'b1;
    for (int i = 0; i < 3; i++) tick_once(1'b0, "R1 no early event");
    tick_once(1'b0, "R2 R6 code3 event at count 4");
    // R7: hold across further ticks without clear, then R8 set-over-clear
    tick_once(1'b0, "R7 hold across tick");
    tick_once(1'b0, "R7 hold across tick");
    tick_once(1'b0, "R7 hold across tick");
    tick_once(1'b1, "R8 event with clear stays set");
    clear_only("R7 clear drops irq");
    // R9: idle cycles without tick produce nothing
    for (int i = 0; i < 10; i++) idle_chk("R9 no tick no event");

    // R4: code 0, then enable low
    rate_code = 4'd0;
    run(40, "R4 code 0 silent");
    rate_code = 4'd3;
    per_en = 1'b0;
    run(40, "R4 enable low silent");
    per_en = 1'b1;

    // R2: codes 3..10, two periods each
    for (int c = 3; c <= 10; c++) begin
      rate_code = 4'(c);
      run(2 * period_of(4'(c)), "R2 rate code sweep");
    end

    // R5: align to count multiple of 16 + 10, then switch period 16 -> 8
    rate_code = 4'd5;
    while ((m_cnt % 16) != 10) run(1, "R5 align");
    rate_code = 4'd4;
    for (int i = 0; i < 5; i++) tick_once(1'b0, "R5 no event before boundary");
    tick_once(1'b0, "R5 event on absolute 8-boundary");
    clear_only("R7 clear");
    // R5: count keeps running while disabled
    per_en = 1'b0;
    run(5, "R5 disabled counting");
    per_en = 1'b1;
    run(20, "R5 re-enable aligned");

    // R3: alias codes
    rate_code = 4'd1;
    run(300, "R3 code1 as 128");
    rate_code = 4'd2;
    run(600, "R3 code2 as 256");

    // R2: slowest code 15 (16384 ticks)
    rate_code = 4'd15;
    run(16400, "R2 code15 period 16384");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule